// File: doc/BRIEF.md
# Peripheral Interrupt Status Register

This block is a byte-wide, memory-mapped interrupt register for a small peripheral controller. It collects five interrupt sources into pending flags and drives a single active-high request line to the CPU. Four sources arrive as event inputs and are caught on their rising edge. The fifth is a frame tick that an internal divider generates.

The register reads and writes differently. A write uses its upper three bits to load the enables of the three maskable sources. A one in any of its lower five bits acknowledges the matching pending flag. A read returns three live status signals in the upper bits and the five pending flags in the lower bits. The enables therefore cannot be read back. Software acknowledges one source at a time by writing a one only in that source's position, and every other pending flag is kept.

The register sits at offset 1 of a two-bit local address inside the controller's chip select. The other offsets are left for neighbouring functions.

Top module: `irq_stat_reg`

## Requirements
- R1: A read with cs=1, rd=1 and addr=1 returns the following. Bit 7 is the baud_in level. Bit 6 is the inverse of motor_on. Bit 5 is the fast status bit. Bits 4..0 are the pending flags.
- R2: The pending flags are set by events. A rising edge on src_evt[0], [1], [2] or [3] sets pending bit 0, 1, 3 or 4 respectively, at the next clock edge. An input that stays high does not set its flag again after it is cleared.
- R3: A write to offset 1 clears every pending flag whose wdata bit (4..0) is 1. Flags whose wdata bit is 0 keep their value.
- R4: Suppose a new event and a clear of the same pending flag happen in the same cycle. The flag is then set afterwards.
- R5: A write to offset 1 loads the enables from wdata bits 7..5. Bit 7 enables pending bit 4, bit 6 enables pending bit 3, and bit 5 enables pending bit 1.
- R6: irq is high exactly when one of these is true:
  - pending bit 0 is set;
  - pending bit 2 is set;
  - a maskable pending flag is set and its enable is on.
- R7: The internal frame source sets pending bit 2 once every FRAME_DIV clock cycles.
- R8: The fast status bit inverts every FAST_HALF clock cycles. With the default of 1, it differs on each pair of consecutive cycles.
- R9: Reads do not change the pending flags or the enables. Writes to other offsets are ignored, and reads at other offsets return 0.
- R10: Reset clears all pending flags and all enables, so irq is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select of the controller |
| addr | input | 2 | Local register offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; combinational, 0 when not selected |
| src_evt | input | 4 | Event inputs of the four external sources |
| baud_in | input | 1 | Serial bit-rate clock, reflected on read bit 7 |
| motor_on | input | 1 | Tape motor running, read inverted on bit 6 |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
A wrong pending flag shows on the very next read of the register. It also changes irq in the same cycle whenever the source is unmaskable or enabled. A lost or spurious clear is therefore visible one clock after the write. The enables cannot be read back, so a wrong enable state shows only through irq. The vectors pair each enable setting with sources on both sides of the mask to expose it. A divider drifting in the frame source shows as a wrong spacing between two successive frame flags, measured in whole cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NPEND = 5;
    localparam int NEN   = 3;
    localparam int NEXT  = 4;
    localparam logic [1:0] REG_OFS = 2'b01;

    typedef struct packed {
        logic [NEN-1:0]   en;
        logic [NPEND-1:0] pend;
        logic             fast;
    } istate_t;

    // External events occupy pending bits 0,1,3,4; the frame tick is bit 2.
    function automatic logic [NPEND-1:0] route_events(logic [NEXT-1:0] e, logic frame);
        return {e[3], e[2], frame, e[1], e[0]};
    endfunction

    // Bits 0 and 2 are always active; enable bits gate bits 1, 3 and 4.
    function automatic logic [NPEND-1:0] active_mask(logic [NEN-1:0] en);
        return {en[2], en[1], 1'b1, en[0], 1'b1};
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = level[i] & ~prev_q[i];
    end

endmodule

// File: rtl/irq_rate_div.sv
module irq_rate_div #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
    import irq_pkg::*;
#(
    parameter int FRAME_DIV = 1000,
    parameter int FAST_HALF = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic [1:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [3:0] src_evt,
    input  logic       baud_in,
    input  logic       motor_on,
    output logic       irq
);

    istate_t st_d, st_q;

    logic [NEXT-1:0]  ext_rise;
    logic             frame_tick;
    logic             fast_tick;
    logic [NPEND-1:0] evt_all;
    logic             sel;
    logic             wr_sel;
    logic [NPEND-1:0] pend_q;
    logic [NEN-1:0]   en_q;

    irq_edge_detect #(.W(NEXT)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (src_evt),
        .rise  (ext_rise)
    );

    irq_rate_div #(.DIV(FRAME_DIV)) frame_div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (frame_tick)
    );

    irq_rate_div #(.DIV(FAST_HALF)) fast_div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (fast_tick)
    );

    assign sel     = cs && (addr == REG_OFS);
    assign wr_sel  = sel && wr;
    assign evt_all = route_events(ext_rise, frame_tick);
    assign pend_q  = st_q.pend;
    assign en_q    = st_q.en;

    always_comb begin
        st_d = st_q;
        if (fast_tick) st_d.fast = ~st_q.fast;
        if (wr_sel) begin
            st_d.en   = wdata[7:5];
            st_d.pend = st_q.pend & ~wdata[NPEND-1:0];
        end
        // new events override a same-cycle clear
        st_d.pend = st_d.pend | evt_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = 8'h00;
        if (sel && rd) rdata = {baud_in, ~motor_on, st_q.fast, st_q.pend};
        irq = |(st_q.pend & active_mask(st_q.en));
    end

endmodule

// File: rtl/irq_stat_reg_chk.sv
module irq_stat_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wsel,
    input logic [7:0] wdata,
    input logic [4:0] evt,
    input logic [4:0] pend,
    input logic [2:0] en,
    input logic       irq
);

    // R2/R4: every event leaves its flag set on the next cycle
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != 5'd0) |=> ((pend & $past(evt)) == $past(evt)));

    // R3: a cleared flag with no new event is gone afterwards
    assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wsel |=> ((pend & $past(wdata[4:0] & ~evt)) == 5'd0));

    // R2: a flag never rises without an event
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == 5'd0));

    // R5/R9: enables hold unless the register is written
    assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wsel |=> $stable(en));

    // R6: no request without pending flags
    assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == 5'd0) |-> !irq);

    // R6: with all masks off only bits 0 and 2 can request
    assert_mask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 3'd0 && !pend[0] && !pend[2]) |-> !irq);

endmodule

bind irq_stat_reg irq_stat_reg_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wsel  (wr_sel),
    .wdata (wdata),
    .evt   (evt_all),
    .pend  (pend_q),
    .en    (en_q),
    .irq   (irq)
);

// File: tb/irq_stat_reg_tb_top.sv
`timescale 1ns/100ps
module irq_stat_reg_tb_top;

    localparam int FDIV = 1000;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cs = 0, rd = 0, wr = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [3:0] src_evt = 0;
    logic       baud_in = 0, motor_on = 0;
    logic       irq;

    int n_run = 0, n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_stat_reg #(.FRAME_DIV(FDIV), .FAST_HALF(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .src_evt(src_evt), .baud_in(baud_in),
        .motor_on(motor_on), .irq(irq)
    );

    // {en[2:0], ev[3:0], clr[4:0], exp_pend[4:0], exp_irq}
    localparam logic [17:0] VEC [10] = '{
        {3'b000, 4'b0001, 5'b00000, 5'b00001, 1'b1},
        {3'b000, 4'b0010, 5'b00000, 5'b00010, 1'b0},
        {3'b001, 4'b0010, 5'b00000, 5'b00010, 1'b1},
        {3'b010, 4'b0100, 5'b00000, 5'b01000, 1'b1},
        {3'b100, 4'b0100, 5'b00000, 5'b01000, 1'b0},
        {3'b100, 4'b1000, 5'b00000, 5'b10000, 1'b1},
        {3'b111, 4'b1111, 5'b00001, 5'b11010, 1'b1},
        {3'b000, 4'b1110, 5'b11010, 5'b00000, 1'b0},
        {3'b011, 4'b1011, 5'b01000, 5'b10011, 1'b1},
        {3'b000, 4'b1010, 5'b00010, 5'b10000, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1; rd = 1; addr = a;
        #1 d = rdata;
        cs = 0; rd = 0;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        src_evt = e;
        @(posedge clk);
        @(negedge clk);
        src_evt = 0;
    endtask

    // wait for a frame flag, then clear everything: ~FDIV quiet cycles follow
    task automatic frame_sync();
        logic [7:0] d;
        d = 0;
        while (!d[2]) rd_reg(2'b01, d);
        wr_reg(2'b01, 8'h1F);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d, d2;
        int t1, t2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R10: reset state (mask fast bit 5)
        rd_reg(2'b01, d);
        chk("R10 read after reset", d & 8'hDF, 8'h40);
        chk("R10 irq after reset", {7'd0, irq}, 8'h00);

        // vector walk: R2 R3 R5 R6
        for (int i = 0; i < 10; i++) begin
            frame_sync();
            wr_reg(2'b01, {VEC[i][17:15], 5'b11111});
            pulse(VEC[i][14:11]);
            wr_reg(2'b01, {VEC[i][17:15], VEC[i][10:6]});
            rd_reg(2'b01, d);
            chk("R2/R3 pending vector", {3'b000, d[4:0]}, {3'b000, VEC[i][5:1]});
            chk("R5/R6 irq vector", {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        // R4: event and clear in the same cycle
        frame_sync();
        @(negedge clk);
        src_evt = 4'b0001; cs = 1; wr = 1; addr = 2'b01; wdata = 8'h01;
        @(posedge clk);
        @(negedge clk);
        cs = 0; wr = 0; src_evt = 0;
        rd_reg(2'b01, d);
        chk("R4 event wins over clear", {7'd0, d[0]}, 8'h01);

        // R2: held level does not re-set after clear
        wr_reg(2'b01, 8'h1F);
        @(negedge clk) src_evt = 4'b0010;
        repeat (2) @(posedge clk);
        wr_reg(2'b01, 8'h02);
        repeat (3) @(posedge clk);
        rd_reg(2'b01, d);
        chk("R2 held level no retrigger", {7'd0, d[1]}, 8'h00);
        @(negedge clk) src_evt = 0;

        // R9: reads keep state, other offsets ignored
        pulse(4'b0001);
        rd_reg(2'b01, d);
        rd_reg(2'b01, d);
        chk("R9 read does not clear", {7'd0, d[0]}, 8'h01);
        wr_reg(2'b00, 8'h1F);
        wr_reg(2'b10, 8'h1F);
        rd_reg(2'b01, d);
        chk("R9 other offset write ignored", {7'd0, d[0]}, 8'h01);
        rd_reg(2'b10, d);
        chk("R9 other offset reads 0", d, 8'h00);

        // R1: live status bits
        baud_in = 1; motor_on = 1;
        rd_reg(2'b01, d);
        chk("R1 baud high motor on", d & 8'hC0, 8'h80);
        baud_in = 0; motor_on = 0;
        rd_reg(2'b01, d);
        chk("R1 baud low motor off", d & 8'hC0, 8'h40);

        // R8: fast bit alternates each cycle
        rd_reg(2'b01, d);
        rd_reg(2'b01, d2);
        chk("R8 fast bit toggles", {7'd0, d[5] ^ d2[5]}, 8'h01);

        // R7: frame period
        wr_reg(2'b01, 8'h1F);
        d = 0;
        while (!d[2]) rd_reg(2'b01, d);
        t1 = cyc;
        wr_reg(2'b01, 8'h04);
        d = 0;
        while (!d[2]) rd_reg(2'b01, d);
        t2 = cyc;
        chk("R7 frame period", 8'(t2 - t1 - FDIV), 8'h00);
        chk("R6 frame unmaskable irq", {7'd0, irq}, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule